// File: doc/BRIEF.md
# I/O Page Table Walker

This block turns a 64-bit device virtual address into a 52-bit physical address. It walks page tables held in memory. A translation request carries the virtual address, the address of the root table and the level at which the walk starts, from 1 to 4. The walker then fetches one 64-bit table entry per step through a plain read port. It follows each entry to the next table, and the entry itself names the level of that next table. One entry can therefore jump over intermediate levels, provided the virtual address bits of the levels it jumps over are zero.

A walk ends in one of two ways. If an entry marks a page, the result is a physical address that keeps the untranslated low bits of the virtual address: 4 KB, 2 MB, 1 GB or larger pages. Otherwise the result is a fault code. Only one walk is in progress at a time. The request side is held off from acceptance until the result is presented.

Top module: `iopt_walker`

## Requirements
- R1: At level L (1 to 4) the table index is virtual address bits [12+9(L-1)+8 : 12+9(L-1)], so level 4 uses 47:39 and level 1 uses 20:12. The entry read address is {table base (40 bits), index (9 bits), 3'b000}. A walk whose entries each step down by exactly one level reads one entry per level, from the start level down to the last level.
- R2: An entry's bits 51:12 give the base of the next table or of the page. Bits 11:9 give the next level. Bit 0 is the present flag. The remaining bits are ignored.
- R3: An entry whose next level N is nonzero and lower than the current level minus one continues the walk directly at level N. Only one entry is read for the levels in between.
- R4: If a skipping entry is followed while any virtual address bit in [12+9N, 12+9(L-1)) is set, the walk ends with fault code 2. No further read is issued.
- R5: An entry with next level 0 at level L ends the walk. The result is fault code 0, and the physical address is the entry's page base with its low 12+9(L-1) bits replaced by the same bits of the virtual address.
- R6: The walk starts at the level and root table given with the request. Bits 11:0 of the root are ignored. Any virtual address bit at or above 12+9*start is a skipped bit and gives fault code 2 with no memory read.
- R7: An entry whose present bit is 0 ends the walk with fault code 1.
- R8: An entry with a nonzero next level that is not below the current level gives fault code 3. A start level of 0 or above 4 gives fault code 3 with no memory read.
- R9: The request-ready output is low from the cycle after acceptance through the result cycle. The result-valid output is a single-cycle pulse. On any fault the physical address output is 0.
- R10: After reset, request-ready is high, and neither a read nor a result is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tr_valid | input | 1 | Translation request present |
| tr_ready | output | 1 | Walker idle, request accepted this cycle if valid |
| tr_vaddr | input | 64 | Virtual address to translate |
| tr_root | input | 52 | Root table address (bits 11:0 ignored) |
| tr_level | input | 3 | Starting level |
| rd_valid | output | 1 | One-cycle table entry read request |
| rd_addr | output | 52 | Byte address of the entry to read |
| rd_resp_valid | input | 1 | Read data present (at least one cycle after the request) |
| rd_resp_data | input | 64 | Table entry returned |
| res_valid | output | 1 | One-cycle result pulse |
| res_paddr | output | 52 | Translated physical address |
| res_fault | output | 2 | 0 none, 1 not present, 2 skipped bits set, 3 bad level |

## Verification
The hardest situation to reach is a level-skipping entry that is followed while a bit of the skipped range is set. The whole chain of tables must be built so that the entry is actually reached, and the set bit must not move any index the walk uses. The bench builds a fresh table set in its memory model for every combination of start level, final level and path shape (step-by-step or single jump). It computes the entry locations from the virtual address. For the fault case it sets one bit strictly inside the jumped-over range, and it also places entries that are absent, have a bad level, or sit above the start range.

// File: rtl/iopt_pkg.sv
package iopt_pkg;
    localparam int VA_W    = 64;
    localparam int PA_W    = 52;
    localparam int ENT_W   = 64;
    localparam int PG_SH   = 12;
    localparam int IDX_W   = 9;
    localparam int LVL_W   = 3;
    localparam int TOP_LVL = 4;
    localparam int ENT_SH  = 3;
    localparam int NL_LSB  = 9;
    localparam int PFN_W   = PA_W - PG_SH;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_ABSENT = 2'd1,
        FLT_SKIP   = 2'd2,
        FLT_LEVEL  = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } state_e;

    typedef struct packed {
        state_e             st;
        logic [VA_W-1:0]    va;
        logic [PFN_W-1:0]   base;
        logic [LVL_W-1:0]   lvl;
        logic [PA_W-1:0]    pa;
        fault_e             flt;
    } walk_s;

    // ones in every bit below the span covered by levels 1..k
    function automatic logic [VA_W-1:0] span_mask(input logic [LVL_W-1:0] k);
        logic [VA_W-1:0] m;
        int w;
        w = PG_SH + IDX_W * int'(k);
        for (int i = 0; i < VA_W; i++) m[i] = (i < w);
        return m;
    endfunction
endpackage

// File: rtl/iopt_index.sv
module iopt_index
    import iopt_pkg::*;
(
    input  logic [VA_W-1:0]  vaddr,
    input  logic [LVL_W-1:0] level,
    input  logic [PFN_W-1:0] base,
    output logic [PA_W-1:0]  ent_addr
);
    logic [IDX_W-1:0] cand [TOP_LVL];
    logic [IDX_W-1:0] idx;

    for (genvar g = 0; g < TOP_LVL; g++) begin : g_lvl
        assign cand[g] = vaddr[PG_SH + IDX_W*g +: IDX_W];
    end

    always_comb begin
        idx = '0;
        for (int l = 1; l <= TOP_LVL; l++) begin
            if (int'(level) == l) idx = cand[l-1];
        end
        ent_addr = {base, idx, {ENT_SH{1'b0}}};
    end
endmodule

// File: rtl/iopt_start_check.sv
module iopt_start_check
    import iopt_pkg::*;
(
    input  logic [VA_W-1:0]  vaddr,
    input  logic [LVL_W-1:0] level,
    output fault_e           fault
);
    always_comb begin
        fault = FLT_NONE;
        if (level == '0 || int'(level) > TOP_LVL)
            fault = FLT_LEVEL;
        else if (|(vaddr & ~span_mask(level)))
            fault = FLT_SKIP;
    end
endmodule

// File: rtl/iopt_entry_eval.sv
module iopt_entry_eval
    import iopt_pkg::*;
(
    input  logic [ENT_W-1:0] entry,
    input  logic [LVL_W-1:0] level,
    input  logic [VA_W-1:0]  vaddr,
    output fault_e           fault,
    output logic             leaf,
    output logic [LVL_W-1:0] next_lvl,
    output logic [PFN_W-1:0] next_base,
    output logic [PA_W-1:0]  leaf_paddr
);
    logic             present;
    logic [VA_W-1:0]  above_mask;
    logic [VA_W-1:0]  skip_mask;
    logic [PA_W-1:0]  off_mask;

    always_comb begin
        present    = entry[0];
        next_lvl   = entry[NL_LSB +: LVL_W];
        next_base  = entry[PG_SH +: PFN_W];
        above_mask = span_mask(LVL_W'(level - 1'b1));
        skip_mask  = above_mask & ~span_mask(next_lvl);
        off_mask   = above_mask[PA_W-1:0];
        leaf_paddr = ({next_base, {PG_SH{1'b0}}} & ~off_mask) | (vaddr[PA_W-1:0] & off_mask);

        fault = FLT_NONE;
        leaf  = 1'b0;
        if (!present)
            fault = FLT_ABSENT;
        else if (next_lvl != '0 && next_lvl >= level)
            fault = FLT_LEVEL;
        else if (next_lvl != '0 && |(vaddr & skip_mask))
            fault = FLT_SKIP;
        else if (next_lvl == '0)
            leaf = 1'b1;
    end
endmodule

// File: rtl/iopt_walker.sv
module iopt_walker
    import iopt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tr_valid,
    output logic             tr_ready,
    input  logic [VA_W-1:0]  tr_vaddr,
    input  logic [PA_W-1:0]  tr_root,
    input  logic [LVL_W-1:0] tr_level,
    output logic             rd_valid,
    output logic [PA_W-1:0]  rd_addr,
    input  logic             rd_resp_valid,
    input  logic [ENT_W-1:0] rd_resp_data,
    output logic             res_valid,
    output logic [PA_W-1:0]  res_paddr,
    output logic [1:0]       res_fault
);
    localparam walk_s WALK_RST = '{st: ST_IDLE, flt: FLT_NONE, default: '0};

    walk_s            walk_q, walk_d;
    fault_e           start_flt;
    fault_e           ev_flt;
    logic             ev_leaf;
    logic [LVL_W-1:0] ev_lvl;
    logic [PFN_W-1:0] ev_base;
    logic [PA_W-1:0]  ev_pa;

    iopt_index u_index (
        .vaddr    (walk_q.va),
        .level    (walk_q.lvl),
        .base     (walk_q.base),
        .ent_addr (rd_addr)
    );

    iopt_start_check u_start (
        .vaddr (tr_vaddr),
        .level (tr_level),
        .fault (start_flt)
    );

    iopt_entry_eval u_eval (
        .entry      (rd_resp_data),
        .level      (walk_q.lvl),
        .vaddr      (walk_q.va),
        .fault      (ev_flt),
        .leaf       (ev_leaf),
        .next_lvl   (ev_lvl),
        .next_base  (ev_base),
        .leaf_paddr (ev_pa)
    );

    always_comb begin
        walk_d = walk_q;
        case (walk_q.st)
            ST_IDLE: begin
                if (tr_valid) begin
                    walk_d.va   = tr_vaddr;
                    walk_d.base = tr_root[PG_SH +: PFN_W];
                    walk_d.lvl  = tr_level;
                    walk_d.pa   = '0;
                    walk_d.flt  = start_flt;
                    walk_d.st   = (start_flt == FLT_NONE) ? ST_ISSUE : ST_DONE;
                end
            end
            ST_ISSUE: walk_d.st = ST_WAIT;
            ST_WAIT: begin
                if (rd_resp_valid) begin
                    if (ev_flt != FLT_NONE) begin
                        walk_d.flt = ev_flt;
                        walk_d.st  = ST_DONE;
                    end else if (ev_leaf) begin
                        walk_d.pa = ev_pa;
                        walk_d.st = ST_DONE;
                    end else begin
                        walk_d.base = ev_base;
                        walk_d.lvl  = ev_lvl;
                        walk_d.st   = ST_ISSUE;
                    end
                end
            end
            default: walk_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) walk_q <= WALK_RST;
        else        walk_q <= walk_d;
    end

    assign tr_ready  = (walk_q.st == ST_IDLE);
    assign rd_valid  = (walk_q.st == ST_ISSUE);
    assign res_valid = (walk_q.st == ST_DONE);
    assign res_paddr = walk_q.pa;
    assign res_fault = walk_q.flt;
endmodule

// File: rtl/iopt_walker_chk.sv
module iopt_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tr_valid,
    input logic        tr_ready,
    input logic        rd_valid,
    input logic [51:0] rd_addr,
    input logic        res_valid,
    input logic [51:0] res_paddr,
    input logic [1:0]  res_fault
);
    // R9
    accept_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tr_valid && tr_ready) |=> !tr_ready);

    // R9
    res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R9
    res_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> tr_ready);

    // R9
    rd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !tr_ready);

    // R1
    rd_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_addr[2:0] == 3'b000));

    // R1
    rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R9
    fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fault != 2'd0) |-> (res_paddr == '0));
endmodule

bind iopt_walker iopt_walker_chk u_chk (.*);

// File: tb/sim_iopt_walker.sv
module sim_iopt_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tr_valid = 1'b0;
    logic        tr_ready;
    logic [63:0] tr_vaddr = '0;
    logic [51:0] tr_root = '0;
    logic [2:0]  tr_level = '0;
    logic        rd_valid;
    logic [51:0] rd_addr;
    logic        rd_resp_valid = 1'b0;
    logic [63:0] rd_resp_data = '0;
    logic        res_valid;
    logic [51:0] res_paddr;
    logic [1:0]  res_fault;

    always #4 clk = ~clk;

    iopt_walker u0 (.*);

    logic [63:0] mem [logic [51:0]];
    int n_chk = 0;
    int n_fail = 0;
    int req_count = 0;
    bit finished = 1'b0;

    function automatic logic [63:0] below(input int n);
        if (n >= 64) return '1;
        return (64'd1 << n) - 64'd1;
    endfunction

    function automatic logic [39:0] tpfn(input int l);
        return 40'h00A00 + 40'(l * 3);
    endfunction

    function automatic logic [51:0] eaddr(input logic [39:0] pfn, input logic [63:0] va, input int l);
        logic [63:0] s;
        s = va >> (12 + 9 * (l - 1));
        return {pfn, s[8:0], 3'b000};
    endfunction

    function automatic logic [63:0] mk_ent(input logic [39:0] pfn, input int nl, input bit pres);
        return {12'h000, pfn, 3'(nl), 8'h00, pres};
    endfunction

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // memory model: answers two cycles after each read request
    initial begin
        forever begin
            @(negedge clk);
            rd_resp_valid = 1'b0;
            if (rd_valid === 1'b1) begin
                logic [51:0] a;
                a = rd_addr;
                req_count++;
                @(negedge clk);
                @(negedge clk);
                rd_resp_data  = mem.exists(a) ? mem[a] : 64'h0;
                rd_resp_valid = 1'b1;
            end
        end
    end

    task automatic walk(input logic [63:0] va, input logic [51:0] root, input logic [2:0] lvl,
                        input logic [1:0] ef, input logic [51:0] epa, input int ereq, input string tag);
        int  cyc;
        bit  rdy_ok;
        @(negedge clk);
        tr_vaddr  = va;
        tr_root   = root;
        tr_level  = lvl;
        tr_valid  = 1'b1;
        req_count = 0;
        @(negedge clk);
        tr_valid = 1'b0;
        cyc      = 0;
        rdy_ok   = 1'b1;
        while (res_valid !== 1'b1 && cyc < 400) begin
            if (tr_ready !== 1'b0) rdy_ok = 1'b0;
            @(negedge clk);
            cyc++;
        end
        if (tr_ready !== 1'b0) rdy_ok = 1'b0;
        chk(tag, "fault code", 64'(res_fault), 64'(ef));
        chk((ef == 2'd0) ? "R5" : "R9", "paddr from entry bits 51:12 (R2)", 64'(res_paddr), 64'(epa));
        chk(tag, "entry reads", 64'(req_count), 64'(ereq));
        chk("R9", "ready low while busy", 64'(rdy_ok), 64'd1);
        @(negedge clk);
        chk("R9", "result pulse ends", 64'(res_valid), 64'd0);
        chk("R9", "ready returns", 64'(tr_ready), 64'd1);
    endtask

    // mode: 0 ok, 1 absent leaf, 2 bad level at first entry, 3 skipped bit set, 4 bit above start range
    task automatic run_case(input int s, input int t, input bit dir, input int mode);
        logic [63:0] va;
        logic [39:0] pg;
        logic [51:0] root;
        logic [51:0] epa;
        logic [1:0]  ef;
        int          nreq;
        int          ereq;
        int          lv;
        int          nx;
        string       tag;
        mem.delete();
        va = {$urandom, $urandom} & below(12 + 9 * s);
        if (dir) va = va & ~(below(12 + 9 * (s - 1)) & ~below(12 + 9 * t));
        if (mode == 3) va = va | (64'd1 << (12 + 9 * t + int'($urandom % (9 * (s - 1 - t)))));
        if (mode == 4) va = va | (64'd1 << (12 + 9 * s + int'($urandom % (52 - 9 * s))));
        pg   = 40'({$urandom, $urandom});
        root = {tpfn(s), 12'($urandom)};
        lv   = s;
        nreq = 0;
        while (lv > t) begin
            nx = dir ? t : lv - 1;
            mem[eaddr(tpfn(lv), va, lv)] = mk_ent(tpfn(nx), nx, 1'b1);
            nreq++;
            lv = nx;
        end
        mem[eaddr(tpfn(t), va, t)] = mk_ent(pg, 0, mode != 1);
        nreq++;
        if (mode == 2) mem[eaddr(tpfn(s), va, s)] = mk_ent(tpfn(s), s, 1'b1);
        epa = '0;
        case (mode)
            0: begin
                ef   = 2'd0;
                epa  = ({pg, 12'h000} & ~below(12 + 9 * (t - 1))) | (va[51:0] & below(12 + 9 * (t - 1)));
                ereq = nreq;
                tag  = dir ? "R3" : "R1";
            end
            1: begin ef = 2'd1; ereq = nreq; tag = "R7"; end
            2: begin ef = 2'd3; ereq = 1;    tag = "R8"; end
            3: begin ef = 2'd2; ereq = 1;    tag = "R4"; end
            default: begin ef = 2'd2; ereq = 0; tag = "R6"; end
        endcase
        walk(va, root, 3'(s), ef, epa, ereq, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "ready after reset", 64'(tr_ready), 64'd1);
        chk("R10", "no read after reset", 64'(rd_valid), 64'd0);
        chk("R10", "no result after reset", 64'(res_valid), 64'd0);

        foreach (mem[k]) mem.delete(k);
        walk(64'h0000_0000_0012_3000, 52'h00A00_0000, 3'd0, 2'd3, '0, 0, "R8");
        walk(64'h0000_0000_0012_3000, 52'h00A00_0000, 3'd5, 2'd3, '0, 0, "R8");
        walk(64'h0000_0000_0012_3000, 52'h00A00_0000, 3'd6, 2'd3, '0, 0, "R8");
        walk(64'h0000_0000_0012_3000, 52'h00A00_0000, 3'd7, 2'd3, '0, 0, "R8");

        for (int rep = 0; rep < 2; rep++) begin
            for (int s = 1; s <= 4; s++) begin
                for (int t = 1; t <= s; t++) begin
                    for (int d = 0; d < 2; d++) begin
                        if (d == 1 && s - t < 2) continue;
                        for (int mode = 0; mode < 5; mode++) begin
                            if (mode == 3 && d == 0) continue;
                            run_case(s, t, d == 1, mode);
                        end
                    end
                end
            end
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung run expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule